// File: doc/BRIEF.md
# Register-Number Bus Arbiter and Data Steering

This block owns an 8-bit register-number bus that several peripheral chips share. Four kinds of requester compete for it. An event-strobe source raises short synthetic codes, such as start-of-vertical-blank, that other chips decode as triggers rather than as register selects. DMA channels move a word between DRAM and a peripheral register. A display-synchronised coprocessor writes an immediate word into a register. The host CPU reads or writes any register. Each clock cycle at most one requester wins. On the next cycle the block places that requester's register number on the bus for exactly one clock. A cycle that selects nothing carries the all-ones idle code.

Along with the register number, the block steers the 16-bit chip data bus to match the winner. For a CPU write it drives the CPU data. For a coprocessor move it drives the move's data word. For a DMA read from memory it drives the DRAM read data. For CPU reads and DMA writes to memory it only listens, passing the peripheral's data to the CPU or to DRAM. The DRAM address and enable are raised only in DMA cycles. Strobe codes are accepted only inside a small parameterised window, so that a faulty code can never select a real register.

Top module: `regbus_master`

## Requirements
- R1: While rst_ni is low, the outputs are: rga_o = 0xFF, src_o = 0, chip_data_oe_o = 0, dram_en_o = 0 and dram_we_o = 0.
- R2: A cycle with no grant in the previous clock shows rga_o = 0xFF and src_o = 0 (idle).
- R3: gnt_o is combinational and at most one-hot, with a fixed priority: bit 0 strobe, above bit 1 DMA, above bit 2 coprocessor, above bit 3 CPU. A requester that loses sees its bit low. gnt_o[3] is the CPU ready signal.
- R4: A grant in cycle t puts that access on the outputs in cycle t+1 only. If no request is present in cycle t+1, cycle t+2 is idle again.
- R5: A CPU write (cpu_we_i = 1) gives src_o = 4, rga_o = cpu_reg_i, chip_data_oe_o = 1 and chip_data_o = cpu_wdata_i.
- R6: A CPU read (cpu_we_i = 0) gives src_o = 4, rga_o = cpu_reg_i and chip_data_oe_o = 0. During that cycle cpu_rdata_o equals chip_data_i.
- R7: A DMA cycle with dma_to_mem_i = 0 gives src_o = 2, rga_o = dma_reg_i, dram_en_o = 1, dram_we_o = 0, dram_addr_o = dma_addr_i, chip_data_oe_o = 1, and chip_data_o following dram_rdata_i. The DRAM enable is high only in DMA cycles.
- R8: A DMA cycle with dma_to_mem_i = 1 gives dram_en_o = 1, dram_we_o = 1 and chip_data_oe_o = 0, with dram_wdata_o equal to chip_data_i.
- R9: A coprocessor move gives src_o = 3, rga_o = cop_reg_i, chip_data_oe_o = 1, chip_data_o = the captured cop_data_i, and dram_en_o = 0.
- R10: A strobe gives src_o = 1, rga_o = the code, chip_data_oe_o = 0 and dram_en_o = 0. Only codes from STB_BASE to STB_BASE+STB_NUM-1 (default 0x00 to 0x03) are valid. A code outside that window is ignored, and the next requester by priority is granted instead.
- R11: Whenever chip_data_oe_o = 0, chip_data_o is 0. In cycles other than a CPU read, cpu_rdata_o is 0. When dram_we_o = 0, dram_wdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_req_i | input | 1 | Strobe request |
| stb_code_i | input | 8 | Strobe code |
| dma_req_i | input | 1 | DMA request |
| dma_reg_i | input | 8 | DMA target register number |
| dma_addr_i | input | 20 | DMA DRAM word address |
| dma_to_mem_i | input | 1 | 1: register to DRAM, 0: DRAM to register |
| cop_req_i | input | 1 | Coprocessor move request |
| cop_reg_i | input | 8 | Move destination register |
| cop_data_i | input | 16 | Move data word |
| cpu_req_i | input | 1 | CPU register access request |
| cpu_reg_i | input | 8 | CPU register number |
| cpu_we_i | input | 1 | CPU write when 1 |
| cpu_wdata_i | input | 16 | CPU write data |
| dram_rdata_i | input | 16 | DRAM read data |
| chip_data_i | input | 16 | Chip data bus as seen from peripherals |
| gnt_o | output | 4 | One-hot grant; bit 3 is CPU ready |
| rga_o | output | 8 | Register-number bus |
| src_o | output | 3 | Cycle owner: 0 idle, 1 strobe, 2 DMA, 3 coprocessor, 4 CPU |
| chip_data_o | output | 16 | Chip data bus drive value |
| chip_data_oe_o | output | 1 | Chip data bus drive enable |
| dram_en_o | output | 1 | DRAM access this cycle |
| dram_we_o | output | 1 | DRAM write this cycle |
| dram_addr_o | output | 20 | DRAM address |
| dram_wdata_o | output | 16 | DRAM write data |
| cpu_rdata_o | output | 16 | CPU read data |

## Verification
Each requester is tried alone: CPU writes and reads, DMA in both directions, coprocessor moves and valid strobes. This separates the data-steering paths, since each one expects a different value and drive state on the chip bus and DRAM pins. Stacked request patterns (all four, then with the winner removed one at a time) tell a correct priority order from a swapped one. A strobe code just outside the valid window, raised together with a CPU request, tells filtering apart from blind acceptance. Back-to-back and single grants followed by silence show that every access lasts exactly one clock and that the bus returns to the idle code.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef enum logic [2:0] {
    SRC_IDLE = 3'd0,
    SRC_STB  = 3'd1,
    SRC_DMA  = 3'd2,
    SRC_COP  = 3'd3,
    SRC_CPU  = 3'd4
  } src_e;

  localparam int NUM_SRC = 4;
  localparam int PRI_STB = 0;
  localparam int PRI_DMA = 1;
  localparam int PRI_COP = 2;
  localparam int PRI_CPU = 3;
endpackage

// File: rtl/regbus_arb.sv
module regbus_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  // lower index wins
  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt_o[i]   = req_i[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req_i[i];
  end
endmodule

// File: rtl/regbus_stb_win.sv
module regbus_stb_win #(
  parameter int          RGA_W = 8,
  parameter logic [7:0]  BASE  = 8'h00,
  parameter int          NUM   = 4
) (
  input  logic             req_i,
  input  logic [RGA_W-1:0] code_i,
  output logic             req_o
);
  localparam int LO = int'(BASE);
  localparam int HI = LO + NUM;

  logic in_win;
  always_comb in_win = (int'(code_i) >= LO) && (int'(code_i) < HI);
  assign req_o = req_i & in_win;
endmodule

// File: rtl/regbus_stage.sv
module regbus_stage
  import regbus_pkg::*;
#(
  parameter int RGA_W   = 8,
  parameter int DATA_W  = 16,
  parameter int DADDR_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] gnt_i,
  input  logic [RGA_W-1:0]   stb_code_i,
  input  logic [RGA_W-1:0]   dma_reg_i,
  input  logic [DADDR_W-1:0] dma_addr_i,
  input  logic               dma_to_mem_i,
  input  logic [RGA_W-1:0]   cop_reg_i,
  input  logic [DATA_W-1:0]  cop_data_i,
  input  logic [RGA_W-1:0]   cpu_reg_i,
  input  logic               cpu_we_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  output src_e               src_o,
  output logic [RGA_W-1:0]   rga_o,
  output logic               drive_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic               dram_en_o,
  output logic               dram_we_o,
  output logic [DADDR_W-1:0] dram_addr_o
);
  localparam logic [RGA_W-1:0] IDLE_CODE = '1;

  src_e               src_d;
  logic [RGA_W-1:0]   rga_d;
  logic               drive_d, en_d, we_d;
  logic [DATA_W-1:0]  wdata_d;
  logic [DADDR_W-1:0] addr_d;

  always_comb begin
    src_d   = SRC_IDLE;
    rga_d   = IDLE_CODE;
    drive_d = 1'b0;
    wdata_d = '0;
    en_d    = 1'b0;
    we_d    = 1'b0;
    addr_d  = '0;
    if (gnt_i[PRI_STB]) begin
      src_d = SRC_STB;
      rga_d = stb_code_i;
    end else if (gnt_i[PRI_DMA]) begin
      src_d   = SRC_DMA;
      rga_d   = dma_reg_i;
      en_d    = 1'b1;
      we_d    = dma_to_mem_i;
      addr_d  = dma_addr_i;
      drive_d = ~dma_to_mem_i;
    end else if (gnt_i[PRI_COP]) begin
      src_d   = SRC_COP;
      rga_d   = cop_reg_i;
      drive_d = 1'b1;
      wdata_d = cop_data_i;
    end else if (gnt_i[PRI_CPU]) begin
      src_d   = SRC_CPU;
      rga_d   = cpu_reg_i;
      drive_d = cpu_we_i;
      wdata_d = cpu_we_i ? cpu_wdata_i : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o       <= SRC_IDLE;
      rga_o       <= IDLE_CODE;
      drive_o     <= 1'b0;
      wdata_o     <= '0;
      dram_en_o   <= 1'b0;
      dram_we_o   <= 1'b0;
      dram_addr_o <= '0;
    end else begin
      src_o       <= src_d;
      rga_o       <= rga_d;
      drive_o     <= drive_d;
      wdata_o     <= wdata_d;
      dram_en_o   <= en_d;
      dram_we_o   <= we_d;
      dram_addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/regbus_steer.sv
module regbus_steer
  import regbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  src_e              src_i,
  input  logic              drive_i,
  input  logic              dram_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dram_rdata_i,
  input  logic [DATA_W-1:0] chip_data_i,
  output logic [DATA_W-1:0] chip_data_o,
  output logic              chip_data_oe_o,
  output logic [DATA_W-1:0] dram_wdata_o,
  output logic [DATA_W-1:0] cpu_rdata_o
);
  always_comb begin
    chip_data_oe_o = drive_i;
    chip_data_o    = '0;
    if (drive_i) chip_data_o = (src_i == SRC_DMA) ? dram_rdata_i : wdata_i;
    dram_wdata_o = dram_we_i ? chip_data_i : '0;
    cpu_rdata_o  = (src_i == SRC_CPU && !drive_i) ? chip_data_i : '0;
  end
endmodule

// File: rtl/regbus_master.sv
module regbus_master
  import regbus_pkg::*;
#(
  parameter int         RGA_W   = 8,
  parameter int         DATA_W  = 16,
  parameter int         DADDR_W = 20,
  parameter logic [7:0] STB_BASE = 8'h00,
  parameter int         STB_NUM  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stb_req_i,
  input  logic [RGA_W-1:0]   stb_code_i,
  input  logic               dma_req_i,
  input  logic [RGA_W-1:0]   dma_reg_i,
  input  logic [DADDR_W-1:0] dma_addr_i,
  input  logic               dma_to_mem_i,
  input  logic               cop_req_i,
  input  logic [RGA_W-1:0]   cop_reg_i,
  input  logic [DATA_W-1:0]  cop_data_i,
  input  logic               cpu_req_i,
  input  logic [RGA_W-1:0]   cpu_reg_i,
  input  logic               cpu_we_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  input  logic [DATA_W-1:0]  dram_rdata_i,
  input  logic [DATA_W-1:0]  chip_data_i,
  output logic [3:0]         gnt_o,
  output logic [RGA_W-1:0]   rga_o,
  output logic [2:0]         src_o,
  output logic [DATA_W-1:0]  chip_data_o,
  output logic               chip_data_oe_o,
  output logic               dram_en_o,
  output logic               dram_we_o,
  output logic [DADDR_W-1:0] dram_addr_o,
  output logic [DATA_W-1:0]  dram_wdata_o,
  output logic [DATA_W-1:0]  cpu_rdata_o
);
  logic               stb_ok;
  logic [NUM_SRC-1:0] req, gnt;
  src_e               src_q;
  logic               drive_q;
  logic [DATA_W-1:0]  wdata_q;

  regbus_stb_win #(.RGA_W(RGA_W), .BASE(STB_BASE), .NUM(STB_NUM)) u_win (
    .req_i (stb_req_i),
    .code_i(stb_code_i),
    .req_o (stb_ok)
  );

  always_comb begin
    req          = '0;
    req[PRI_STB] = stb_ok;
    req[PRI_DMA] = dma_req_i;
    req[PRI_COP] = cop_req_i;
    req[PRI_CPU] = cpu_req_i;
  end

  regbus_arb #(.N(NUM_SRC)) u_arb (.req_i(req), .gnt_o(gnt));

  regbus_stage #(.RGA_W(RGA_W), .DATA_W(DATA_W), .DADDR_W(DADDR_W)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_i       (gnt),
    .stb_code_i  (stb_code_i),
    .dma_reg_i   (dma_reg_i),
    .dma_addr_i  (dma_addr_i),
    .dma_to_mem_i(dma_to_mem_i),
    .cop_reg_i   (cop_reg_i),
    .cop_data_i  (cop_data_i),
    .cpu_reg_i   (cpu_reg_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_wdata_i (cpu_wdata_i),
    .src_o       (src_q),
    .rga_o       (rga_o),
    .drive_o     (drive_q),
    .wdata_o     (wdata_q),
    .dram_en_o   (dram_en_o),
    .dram_we_o   (dram_we_o),
    .dram_addr_o (dram_addr_o)
  );

  regbus_steer #(.DATA_W(DATA_W)) u_steer (
    .src_i         (src_q),
    .drive_i       (drive_q),
    .dram_we_i     (dram_we_o),
    .wdata_i       (wdata_q),
    .dram_rdata_i  (dram_rdata_i),
    .chip_data_i   (chip_data_i),
    .chip_data_o   (chip_data_o),
    .chip_data_oe_o(chip_data_oe_o),
    .dram_wdata_o  (dram_wdata_o),
    .cpu_rdata_o   (cpu_rdata_o)
  );

  assign gnt_o = gnt;
  assign src_o = src_q;
endmodule

// File: rtl/regbus_chk.sv
module regbus_chk #(
  parameter int RGA_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dma_req_i,
  input logic [RGA_W-1:0]  dma_reg_i,
  input logic              cop_req_i,
  input logic [DATA_W-1:0] cop_data_i,
  input logic              cpu_req_i,
  input logic [3:0]        gnt_o,
  input logic [RGA_W-1:0]  rga_o,
  input logic [2:0]        src_o,
  input logic [DATA_W-1:0] chip_data_o,
  input logic              chip_data_oe_o,
  input logic              dram_en_o
);
  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == 3'd0) |-> (rga_o == '1)); // R2
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R3
  AST_CPU_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && (dma_req_i || cop_req_i)) |-> !gnt_o[3]); // R3
  AST_DMA_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[1] |=> (src_o == 3'd2 && rga_o == $past(dma_reg_i))); // R4
  AST_COP_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[2] |=> (src_o == 3'd3 && chip_data_oe_o && chip_data_o == $past(cop_data_i))); // R9
  AST_DRAM_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_en_o |-> (src_o == 3'd2)); // R7
  AST_STB_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == 3'd1) |-> (!chip_data_oe_o && !dram_en_o)); // R10
  AST_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_data_oe_o |-> (chip_data_o == '0)); // R11
endmodule

bind regbus_master regbus_chk #(.RGA_W(RGA_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dma_req_i     (dma_req_i),
  .dma_reg_i     (dma_reg_i),
  .cop_req_i     (cop_req_i),
  .cop_data_i    (cop_data_i),
  .cpu_req_i     (cpu_req_i),
  .gnt_o         (gnt_o),
  .rga_o         (rga_o),
  .src_o         (src_o),
  .chip_data_o   (chip_data_o),
  .chip_data_oe_o(chip_data_oe_o),
  .dram_en_o     (dram_en_o)
);

// File: tb/sim_regbus_master.sv
`timescale 1ns/1ps
module sim_regbus_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stb_req = 0, dma_req = 0, dma_to_mem = 0, cop_req = 0, cpu_req = 0, cpu_we = 0;
  logic [7:0] stb_code = 0, dma_reg = 0, cop_reg = 0, cpu_reg = 0;
  logic [19:0] dma_addr = 0;
  logic [15:0] cop_data = 0, cpu_wdata = 0, dram_rdata = 0, chip_in = 0;
  logic [3:0] gnt;
  logic [7:0] rga;
  logic [2:0] src;
  logic [15:0] chip_out, dram_wdata, cpu_rdata;
  logic oe, dram_en, dram_we;
  logic [19:0] dram_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  regbus_master u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .stb_req_i(stb_req), .stb_code_i(stb_code),
    .dma_req_i(dma_req), .dma_reg_i(dma_reg), .dma_addr_i(dma_addr), .dma_to_mem_i(dma_to_mem),
    .cop_req_i(cop_req), .cop_reg_i(cop_reg), .cop_data_i(cop_data),
    .cpu_req_i(cpu_req), .cpu_reg_i(cpu_reg), .cpu_we_i(cpu_we), .cpu_wdata_i(cpu_wdata),
    .dram_rdata_i(dram_rdata), .chip_data_i(chip_in),
    .gnt_o(gnt), .rga_o(rga), .src_o(src), .chip_data_o(chip_out), .chip_data_oe_o(oe),
    .dram_en_o(dram_en), .dram_we_o(dram_we), .dram_addr_o(dram_addr),
    .dram_wdata_o(dram_wdata), .cpu_rdata_o(cpu_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    stb_req = 0; dma_req = 0; cop_req = 0; cpu_req = 0;
  endtask

  task automatic t_reset();
    #3;
    check("R1 rga", rga, 8'hFF);
    check("R1 src", src, 0);
    check("R1 oe", oe, 0);
    check("R1 dram_en", dram_en, 0);
    check("R1 dram_we", dram_we, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic t_idle();
    cyc();
    check("R2 idle rga", rga, 8'hFF);
    check("R2 idle src", src, 0);
    check("R11 idle data", chip_out, 0);
  endtask

  task automatic t_cpu_write();
    cpu_req = 1; cpu_we = 1; cpu_reg = 8'h4A; cpu_wdata = 16'hBEEF;
    #1 check("R3 cpu ready", gnt, 4'b1000);
    @(negedge clk); clr();
    check("R5 rga", rga, 8'h4A);
    check("R5 src", src, 4);
    check("R5 oe", oe, 1);
    check("R5 data", chip_out, 16'hBEEF);
    check("R11 cpu_rdata", cpu_rdata, 0);
    cyc();
    check("R4 back idle", rga, 8'hFF);
  endtask

  task automatic t_cpu_read();
    cpu_req = 1; cpu_we = 0; cpu_reg = 8'h1C; chip_in = 16'h5A3C;
    cyc(); clr();
    check("R6 rga", rga, 8'h1C);
    check("R6 oe", oe, 0);
    check("R6 rdata", cpu_rdata, 16'h5A3C);
    check("R11 data", chip_out, 0);
    cyc();
    check("R11 rdata idle", cpu_rdata, 0);
  endtask

  task automatic t_dma_read();
    dma_req = 1; dma_to_mem = 0; dma_reg = 8'h6E; dma_addr = 20'h12345;
    cyc(); clr();
    dram_rdata = 16'hC0DE; #1;
    check("R7 rga", rga, 8'h6E);
    check("R7 src", src, 2);
    check("R7 en", dram_en, 1);
    check("R7 we", dram_we, 0);
    check("R7 addr", dram_addr, 20'h12345);
    check("R7 oe", oe, 1);
    check("R7 data", chip_out, 16'hC0DE);
    cyc();
    check("R7 en off", dram_en, 0);
  endtask

  task automatic t_dma_write();
    dma_req = 1; dma_to_mem = 1; dma_reg = 8'h22; dma_addr = 20'hABCDE; chip_in = 16'h7711;
    cyc(); clr();
    check("R8 en", dram_en, 1);
    check("R8 we", dram_we, 1);
    check("R8 oe", oe, 0);
    check("R8 wdata", dram_wdata, 16'h7711);
    check("R8 addr", dram_addr, 20'hABCDE);
    cyc();
    check("R11 wdata idle", dram_wdata, 0);
  endtask

  task automatic t_cop();
    cop_req = 1; cop_reg = 8'h80; cop_data = 16'h0F0F;
    cyc(); clr(); cop_data = 16'hFFFF;
    check("R9 rga", rga, 8'h80);
    check("R9 src", src, 3);
    check("R9 oe", oe, 1);
    check("R9 data", chip_out, 16'h0F0F);
    check("R9 dram", dram_en, 0);
  endtask

  task automatic t_strobe();
    stb_req = 1; stb_code = 8'h03;
    cyc(); clr();
    check("R10 rga", rga, 8'h03);
    check("R10 src", src, 1);
    check("R10 oe", oe, 0);
    check("R10 dram", dram_en, 0);
    stb_req = 1; stb_code = 8'h04; cpu_req = 1; cpu_we = 0; cpu_reg = 8'h30;
    #1 check("R10 bad code gnt", gnt, 4'b1000);
    @(negedge clk); clr();
    check("R10 bad code rga", rga, 8'h30);
    check("R10 bad code src", src, 4);
  endtask

  task automatic t_priority();
    stb_req = 1; stb_code = 8'h01; dma_req = 1; dma_to_mem = 0; dma_reg = 8'h44;
    cop_req = 1; cop_reg = 8'h55; cpu_req = 1; cpu_reg = 8'h66; cpu_we = 0;
    #1 check("R3 all", gnt, 4'b0001);
    @(negedge clk);
    check("R4 stb rga", rga, 8'h01);
    stb_req = 0; #1 check("R3 dma wins", gnt, 4'b0010);
    @(negedge clk);
    check("R4 dma rga", rga, 8'h44);
    dma_req = 0; #1 check("R3 cop wins", gnt, 4'b0100);
    @(negedge clk);
    check("R4 cop rga", rga, 8'h55);
    cop_req = 0; #1 check("R3 cpu wins", gnt, 4'b1000);
    @(negedge clk); clr();
    check("R4 cpu rga", rga, 8'h66);
    #1 check("R3 none", gnt, 4'b0000);
    cyc();
    check("R4 idle after", rga, 8'hFF);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_cpu_write();
    t_cpu_read();
    t_dma_read();
    t_dma_write();
    t_cop();
    t_strobe();
    t_priority();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule